// File: doc/BRIEF.md
# Chip Power Mode Sequencer

This block is the power-state controller of a small system. It walks the chip through five states: off, on, light sleep, deep sleep and a wakeup stage. From the current state it drives the rail enables, the crystal and PLL enables, a reset for the non-retained logic, a retention enable and a clock enable for each block. The crystal, the PLL and the regulators are not modelled here. They appear only as enable outputs, with ready and lock inputs coming back.

Firmware reaches the block through a simple write port. Address 0 carries a sleep request, address 1 sets the wake-timer interval and address 2 sets the per-block clock mask. The two sleep depths keep different domains powered and also leave by different routes.

- Light sleep keeps the main domain powered. Any wake source ends it.
- Deep sleep keeps only the always-on domain and its retention memory. Only the timer or an external interrupt can end it, and the exit passes through a full reset of everything that was not retained.

The cause of the most recent wake is latched as a source vector.

Top module: `pmode_sequencer`

## Requirements
- R1: While chip_en is low, the next clock edge puts the block in OFF. State codes are OFF=0, ON=1, SLEEP=2, DEEP=3, WAKEUP=4. In OFF every enable output is low and core_rst_n is low. The wake_src, timeout_err, clock mask and timer interval are all cleared to zero.
- R2: When chip_en is high in OFF, the next edge enters WAKEUP. In WAKEUP, xtal_en and pll_en are high and core_rst_n is low. In the first cycle in which xtal_ready and pll_lock are both high, the next edge enters ON, where core_rst_n is high.
- R3: A write to address 2 loads the clock mask on that edge. In ON, blk_clk_en equals the mask. In every other state, blk_clk_en is zero.
- R4: In ON, cpu_clk_en is the inverse of wfi_req, and wfi_req has no effect on blk_clk_en.
- R5: A write to address 0 is a sleep request. Bit 0 asks for SLEEP and bit 1 asks for DEEP; when both are set, DEEP wins. The request changes state on the same edge only if the state is ON. In any other state it is ignored.
- R6: In SLEEP, main_pwr_en and core_rst_n stay high. xtal_en, pll_en, retain_en and all clock enables are low.
- R7: A write to address 1 sets the wake interval N. With N nonzero, the timer ends a SLEEP or DEEP stay after exactly N cycles. N=0 disables the timer.
- R8: SLEEP goes to WAKEUP on the edge after any wake source is high. The source vector is latched into wake_src: bit 0 timer, bit 1 wake_mac, bit 2 wake_host, bit 3 wake_ext.
- R9: In DEEP, only rtc_pwr_en and retain_en are high. wake_mac and wake_host are ignored. The timer or wake_ext moves the block to WAKEUP, and core_rst_n stays low there until ON.
- R10: If WAKEUP lasts LOCK_TMO cycles without both ready inputs high, the block returns to SLEEP and sets timeout_err. The flag stays set until chip_en goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable; low forces OFF and clears state |
| wake_mac | input | 1 | Radio MAC wake event |
| wake_host | input | 1 | Host wake event |
| wake_ext | input | 1 | External interrupt wake event |
| xtal_ready | input | 1 | Crystal oscillator ready |
| pll_lock | input | 1 | PLL locked |
| wfi_req | input | 1 | CPU wait-for-interrupt, gates the CPU clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 sleep, 1 interval, 2 mask) |
| cfg_wdata | input | TW | Register write data |
| pm_state | output | 3 | Current state code |
| rtc_pwr_en | output | 1 | Always-on domain power enable |
| main_pwr_en | output | 1 | Main domain power enable |
| retain_en | output | 1 | Retention memory hold enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_rst_n | output | 1 | Reset of non-retained logic, active low |
| blk_clk_en | output | NBLK | Per-block fast clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| wake_src | output | 4 | Latched source vector of the last wake |
| timeout_err | output | 1 | Sticky wakeup-timeout flag |

## Verification
Wakeups are driven by each source in turn: the timer, a MAC pulse and an external pulse. Because wake_src latches the source vector, the bench can tell which path actually fired. The MAC pulse is applied once in light sleep and once in deep sleep, which separates the two exit rules. Sleep requests are issued in ON, and also in a WAKEUP stage held open by a missing lock, to show that the state gating works. Stays in SLEEP and WAKEUP are counted cycle by cycle against the programmed interval and the timeout, which exposes off-by-one errors in either counter.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

  typedef enum logic [2:0] {
    PM_OFF   = 3'd0,
    PM_ON    = 3'd1,
    PM_SLEEP = 3'd2,
    PM_DEEP  = 3'd3,
    PM_WAKE  = 3'd4
  } pm_state_e;

  localparam logic [1:0] ADDR_SLEEP = 2'd0;
  localparam logic [1:0] ADDR_IVAL  = 2'd1;
  localparam logic [1:0] ADDR_MASK  = 2'd2;

  // wake source bit positions
  localparam int SRC_TMR  = 0;
  localparam int SRC_MAC  = 1;
  localparam int SRC_HOST = 2;
  localparam int SRC_EXT  = 3;

  typedef struct packed {
    logic rtc;
    logic main;
    logic retain;
    logic xtal;
    logic pll;
    logic core_rst_n;
    logic clk_run;
  } pm_rails_t;

  // rail pattern for each state; deep_path holds core reset through WAKEUP
  function automatic pm_rails_t rails_of(input pm_state_e s, input logic deep_path);
    pm_rails_t r;
    r = '0;
    case (s)
      PM_ON:    begin r.rtc = 1'b1; r.main = 1'b1; r.xtal = 1'b1; r.pll = 1'b1;
                      r.core_rst_n = 1'b1; r.clk_run = 1'b1; end
      PM_SLEEP: begin r.rtc = 1'b1; r.main = 1'b1; r.core_rst_n = 1'b1; end
      PM_DEEP:  begin r.rtc = 1'b1; r.retain = 1'b1; end
      PM_WAKE:  begin r.rtc = 1'b1; r.main = 1'b1; r.xtal = 1'b1; r.pll = 1'b1;
                      r.core_rst_n = !deep_path; end
      default:  r = '0;
    endcase
    return r;
  endfunction

  // a counter started at zero hits its last cycle when cnt == limit-1
  function automatic logic last_cycle(input logic [31:0] cnt, input logic [31:0] limit);
    return (limit != 32'd0) && (cnt == limit - 32'd1);
  endfunction

  // which wake sources each state listens to
  function automatic logic [3:0] wake_allow(input pm_state_e s);
    case (s)
      PM_SLEEP: return 4'b1111;
      PM_DEEP:  return 4'b1001;
      default:  return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/pmseq_wake_timer.sv
module pmseq_wake_timer
  import pmseq_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          ival_we,
  input  logic [TW-1:0] ival_d,
  output logic          expire
);
  logic [TW-1:0] ival_q;
  logic [TW-1:0] cnt_q;

  assign expire = run && last_cycle(32'(cnt_q), 32'(ival_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      ival_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ival_we) ival_q <= ival_d;
      if (!run || expire) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: while running with a nonzero interval the count stays below it
  a_r7_cnt_below_ival: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ival_q != '0 && !clr && !ival_we) |-> (cnt_q < ival_q));

endmodule

// File: rtl/pmseq_lock_wait.sv
module pmseq_lock_wait
  import pmseq_pkg::*;
#(
  parameter int LOCK_TMO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  input  logic xtal_ready,
  input  logic pll_lock,
  output logic locked,
  output logic tmo
);
  localparam int CW = $clog2(LOCK_TMO + 1);
  logic [CW-1:0] cnt_q;

  assign locked = active && xtal_ready && pll_lock;
  assign tmo    = active && !locked && last_cycle(32'(cnt_q), 32'(LOCK_TMO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt_q <= '0;
    else if (clr || !active || locked || tmo) cnt_q <= '0;
    else                                cnt_q <= cnt_q + 1'b1;
  end

  // R10: the wait counter never reaches the timeout limit itself
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < 32'(LOCK_TMO));

endmodule

// File: rtl/pmseq_clk_gate.sv
module pmseq_clk_gate #(
  parameter int NBLK = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            mask_we,
  input  logic [NBLK-1:0] mask_d,
  input  logic            run,
  input  logic            wfi_req,
  output logic [NBLK-1:0] blk_clk_en,
  output logic            cpu_clk_en
);
  logic [NBLK-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (clr)     mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_gate
    assign blk_clk_en[i] = run && mask_q[i];
  end

  assign cpu_clk_en = run && !wfi_req;

  // R3: a mask write while running shows on the enables one cycle later
  a_r3_mask_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !clr && run) |=> (!run || blk_clk_en == $past(mask_d)));

endmodule

// File: rtl/pmode_sequencer.sv
module pmode_sequencer
  import pmseq_pkg::*;
#(
  parameter int NBLK     = 8,
  parameter int TW       = 16,
  parameter int LOCK_TMO = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chip_en,
  input  logic            wake_mac,
  input  logic            wake_host,
  input  logic            wake_ext,
  input  logic            xtal_ready,
  input  logic            pll_lock,
  input  logic            wfi_req,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [TW-1:0]   cfg_wdata,
  output logic [2:0]      pm_state,
  output logic            rtc_pwr_en,
  output logic            main_pwr_en,
  output logic            retain_en,
  output logic            xtal_en,
  output logic            pll_en,
  output logic            core_rst_n,
  output logic [NBLK-1:0] blk_clk_en,
  output logic            cpu_clk_en,
  output logic [3:0]      wake_src,
  output logic            timeout_err
);
  localparam int SLP_LIGHT_BIT = 0;
  localparam int SLP_DEEP_BIT  = 1;

  pm_state_e state_q, state_n;
  logic      deep_q, deep_n;
  logic      err_q, err_n;
  logic [3:0] src_q, src_n;

  // named internal events
  logic      clr;
  logic      tmr_expire;
  logic      lk_locked, lk_tmo;
  logic      slp_wr, ival_wr, mask_wr;
  logic      req_light, req_deep;
  logic [3:0] evt_vec, evt_live;
  logic      wake_hit;
  pm_rails_t rails;

  assign clr       = !chip_en;
  assign slp_wr    = cfg_we && cfg_addr == ADDR_SLEEP;
  assign ival_wr   = cfg_we && cfg_addr == ADDR_IVAL;
  assign mask_wr   = cfg_we && cfg_addr == ADDR_MASK;
  assign req_deep  = slp_wr && cfg_wdata[SLP_DEEP_BIT];
  assign req_light = slp_wr && cfg_wdata[SLP_LIGHT_BIT] && !cfg_wdata[SLP_DEEP_BIT];

  assign evt_vec[SRC_TMR]  = tmr_expire;
  assign evt_vec[SRC_MAC]  = wake_mac;
  assign evt_vec[SRC_HOST] = wake_host;
  assign evt_vec[SRC_EXT]  = wake_ext;
  assign evt_live = evt_vec & wake_allow(state_q);
  assign wake_hit = |evt_live;

  pmseq_wake_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .run     (state_q == PM_SLEEP || state_q == PM_DEEP),
    .ival_we (ival_wr),
    .ival_d  (cfg_wdata),
    .expire  (tmr_expire)
  );

  pmseq_lock_wait #(.LOCK_TMO(LOCK_TMO)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .active     (state_q == PM_WAKE),
    .xtal_ready (xtal_ready),
    .pll_lock   (pll_lock),
    .locked     (lk_locked),
    .tmo        (lk_tmo)
  );

  assign rails = rails_of(state_q, deep_q);

  pmseq_clk_gate #(.NBLK(NBLK)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .mask_we    (mask_wr),
    .mask_d     (cfg_wdata[NBLK-1:0]),
    .run        (rails.clk_run),
    .wfi_req    (wfi_req),
    .blk_clk_en (blk_clk_en),
    .cpu_clk_en (cpu_clk_en)
  );

  always_comb begin
    state_n = state_q;
    deep_n  = deep_q;
    err_n   = err_q;
    src_n   = src_q;
    case (state_q)
      PM_OFF: begin
        state_n = PM_WAKE;
        deep_n  = 1'b1;
      end
      PM_ON: begin
        if (req_deep)       state_n = PM_DEEP;
        else if (req_light) state_n = PM_SLEEP;
      end
      PM_SLEEP: if (wake_hit) begin
        state_n = PM_WAKE;
        deep_n  = 1'b0;
        src_n   = evt_live;
      end
      PM_DEEP: if (wake_hit) begin
        state_n = PM_WAKE;
        deep_n  = 1'b1;
        src_n   = evt_live;
      end
      PM_WAKE: begin
        if (lk_locked) begin
          state_n = PM_ON;
          deep_n  = 1'b0;
        end else if (lk_tmo) begin
          state_n = PM_SLEEP;
          deep_n  = 1'b0;
          err_n   = 1'b1;
        end
      end
      default: state_n = PM_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || clr) begin
      state_q <= PM_OFF;
      deep_q  <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
    end else begin
      state_q <= state_n;
      deep_q  <= deep_n;
      err_q   <= err_n;
      src_q   <= src_n;
    end
  end

  assign pm_state    = state_q;
  assign rtc_pwr_en  = rails.rtc;
  assign main_pwr_en = rails.main;
  assign retain_en   = rails.retain;
  assign xtal_en     = rails.xtal;
  assign pll_en      = rails.pll;
  assign core_rst_n  = rails.core_rst_n;
  assign wake_src    = src_q;
  assign timeout_err = err_q;

  // R1: chip enable low forces OFF with the always-on rail dropped
  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (state_q == PM_OFF && !rtc_pwr_en && !timeout_err));

  // R5: deep sleep is only ever entered from ON
  a_r5_deep_from_on: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_DEEP && $past(state_q) != PM_DEEP) |-> ($past(state_q) == PM_ON));

  // R7: a timer expiry in SLEEP leads to WAKEUP
  a_r7_timer_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && state_q == PM_SLEEP && tmr_expire) |=> (state_q == PM_WAKE));

  // R9: in DEEP, only the timer or the external line can end the stay
  a_r9_deep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && state_q == PM_DEEP && !wake_ext && !tmr_expire) |=> (state_q == PM_DEEP));

  // R9: deep exit keeps the core in reset through WAKEUP
  a_r9_deep_exit_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && state_q == PM_DEEP && wake_hit) |=> (state_q == PM_WAKE && !core_rst_n));

  // R10: timeout returns to SLEEP with the flag raised
  a_r10_timeout_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && state_q == PM_WAKE && lk_tmo) |=> (state_q == PM_SLEEP && timeout_err));

endmodule

// File: tb/pmode_sequencer_bench.sv
module pmode_sequencer_bench;
  localparam int NBLK = 8;
  localparam int TW   = 16;
  localparam int TMO  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0;
  logic wake_mac = 1'b0, wake_host = 1'b0, wake_ext = 1'b0;
  logic xtal_ready = 1'b1, pll_lock = 1'b1, wfi_req = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic [2:0] pm_state;
  logic rtc_pwr_en, main_pwr_en, retain_en, xtal_en, pll_en, core_rst_n;
  logic [NBLK-1:0] blk_clk_en;
  logic cpu_clk_en;
  logic [3:0] wake_src;
  logic timeout_err;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [2:0] S_OFF = 3'd0, S_ON = 3'd1, S_SLP = 3'd2, S_DEEP = 3'd3, S_WAKE = 3'd4;

  always #5 clk = ~clk;

  pmode_sequencer #(.NBLK(NBLK), .TW(TW), .LOCK_TMO(TMO)) u_pmode_sequencer (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
    .wake_mac(wake_mac), .wake_host(wake_host), .wake_ext(wake_ext),
    .xtal_ready(xtal_ready), .pll_lock(pll_lock), .wfi_req(wfi_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pm_state(pm_state), .rtc_pwr_en(rtc_pwr_en), .main_pwr_en(main_pwr_en),
    .retain_en(retain_en), .xtal_en(xtal_en), .pll_en(pll_en),
    .core_rst_n(core_rst_n), .blk_clk_en(blk_clk_en), .cpu_clk_en(cpu_clk_en),
    .wake_src(wake_src), .timeout_err(timeout_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [TW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  // rails packed as {rtc,main,retain,xtal,pll,core_rst_n}
  function automatic int rails();
    return int'({rtc_pwr_en, main_pwr_en, retain_en, xtal_en, pll_en, core_rst_n});
  endfunction

  task automatic t_reset();
    check("R1", "state after reset", pm_state, S_OFF);
    check("R1", "rails in OFF", rails(), 0);
    check("R1", "clocks in OFF", {blk_clk_en, cpu_clk_en}, 0);
  endtask

  task automatic t_powerup();
    chip_en = 1'b1;
    tick();
    check("R2", "state after enable", pm_state, S_WAKE);
    check("R2", "wakeup rails", rails(), 6'b110110);
    tick();
    check("R2", "state once locked", pm_state, S_ON);
    check("R2", "core reset released", core_rst_n, 1);
    check("R3", "cleared mask gives no clocks", blk_clk_en, 0);
  endtask

  task automatic t_mask_wfi();
    cfg_write(2'd2, 16'h00A5);
    check("R3", "mask applied", blk_clk_en, 8'hA5);
    check("R4", "cpu clock runs", cpu_clk_en, 1);
    wfi_req = 1'b1; #1;
    check("R4", "cpu clock gated by wfi", cpu_clk_en, 0);
    check("R4", "block clocks unaffected by wfi", blk_clk_en, 8'hA5);
    wfi_req = 1'b0; #1;
  endtask

  task automatic t_timer_sleep();
    int n;
    cfg_write(2'd1, 16'd5);
    cfg_write(2'd0, 16'h0001);
    check("R5", "light request enters SLEEP", pm_state, S_SLP);
    check("R6", "sleep rails", rails(), 6'b110001);
    check("R6", "sleep clocks off", {blk_clk_en, cpu_clk_en}, 0);
    n = 0;
    while (pm_state == S_SLP && n < 100) begin tick(); n++; end
    check("R7", "sleep residence cycles", n, 5);
    check("R8", "timer wake source", wake_src, 4'b0001);
    check("R8", "state after timer", pm_state, S_WAKE);
    tick();
    check("R2", "back to ON", pm_state, S_ON);
    check("R3", "mask kept over sleep", blk_clk_en, 8'hA5);
  endtask

  task automatic t_mac_sleep();
    cfg_write(2'd1, 16'd0);
    cfg_write(2'd0, 16'h0001);
    repeat (40) tick();
    check("R7", "zero interval keeps sleeping", pm_state, S_SLP);
    wake_mac = 1'b1; tick(); wake_mac = 1'b0;
    check("R8", "mac ends light sleep", pm_state, S_WAKE);
    check("R8", "mac wake source", wake_src, 4'b0010);
    check("R8", "light exit keeps core out of reset", core_rst_n, 1);
    tick();
  endtask

  task automatic t_deep();
    cfg_write(2'd0, 16'h0003);
    check("R5", "deep wins over light", pm_state, S_DEEP);
    check("R9", "deep rails", rails(), 6'b101000);
    wake_mac = 1'b1; wake_host = 1'b1; tick(); wake_mac = 1'b0; wake_host = 1'b0;
    check("R9", "mac and host ignored in DEEP", pm_state, S_DEEP);
    tick();
    wake_ext = 1'b1; tick(); wake_ext = 1'b0;
    check("R9", "ext ends deep sleep", pm_state, S_WAKE);
    check("R9", "core held in reset on deep exit", core_rst_n, 0);
    check("R8", "ext wake source", wake_src, 4'b1000);
    tick();
    check("R9", "ON after deep exit", pm_state, S_ON);
    check("R9", "core released in ON", core_rst_n, 1);
    cfg_write(2'd1, 16'd3);
    cfg_write(2'd0, 16'h0002);
    repeat (3) tick();
    check("R7", "timer ends deep sleep", pm_state, S_WAKE);
    check("R8", "deep timer source", wake_src, 4'b0001);
    tick();
  endtask

  task automatic t_timeout();
    int n;
    cfg_write(2'd1, 16'd0);
    xtal_ready = 1'b0;
    cfg_write(2'd0, 16'h0001);
    wake_host = 1'b1; tick(); wake_host = 1'b0;
    check("R8", "host wake source", wake_src, 4'b0100);
    cfg_write(2'd0, 16'h0002);
    check("R5", "sleep request ignored in WAKEUP", pm_state, S_WAKE);
    n = 1;
    while (pm_state == S_WAKE && n < 200) begin tick(); n++; end
    check("R10", "wakeup residence before timeout", n, TMO);
    check("R10", "timeout returns to SLEEP", pm_state, S_SLP);
    check("R10", "timeout flag set", timeout_err, 1);
    cfg_write(2'd0, 16'h0002);
    check("R5", "sleep request ignored in SLEEP", pm_state, S_SLP);
    xtal_ready = 1'b1;
    wake_ext = 1'b1; tick(); wake_ext = 1'b0;
    tick();
    check("R10", "ON after retry", pm_state, S_ON);
    check("R10", "flag is sticky", timeout_err, 1);
  endtask

  task automatic t_chip_off();
    chip_en = 1'b0;
    tick();
    check("R1", "OFF on disable", pm_state, S_OFF);
    check("R1", "rails off", rails(), 0);
    check("R1", "flag cleared", timeout_err, 0);
    check("R1", "source cleared", wake_src, 0);
    chip_en = 1'b1;
    tick(); tick();
    check("R1", "mask cleared by disable", blk_clk_en, 0);
    cfg_write(2'd0, 16'h0001);
    repeat (10) tick();
    check("R1", "interval cleared by disable", pm_state, S_SLP);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    t_reset();
    t_powerup();
    t_mask_wfi();
    t_timer_sleep();
    t_mac_sleep();
    t_deep();
    t_timeout();
    t_chip_off();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule